// File: doc/BRIEF.md
# Interlaced Raster Position Generator

This block produces the running beam position of a CRT-style video timing chain. A dot-clock enable steps a dot counter through each line, and the dot counter steps a line counter through each field. An odd/even field flag changes when the line counter wraps, if interlace is enabled. A frame counter and a one-cycle frame tick mark the point in each field where the retrace line is reached. The line length and the line count come from a total register. Sync widths and the front porch come from two timing registers. Interlace comes from a mode register. All four are loaded through a single-cycle write port.

A combinational sync-status word can be placed on a register read path. It shows the current line, the field and three phase flags: display active, horizontal sync released and vertical sync released. How the phase flags are decoded depends on whether the parity of the current line equals the field flag. On matching lines the flags follow the horizontal sync width and the front porch. On the other lines they follow the line length less a fixed back porch.

Top module: `scan_raster`

## Requirements
- R1: A write with `wr_sel` = 0 loads the total register from bits 25:16 (line count minus one) and bits 9:0 (dots per line minus one). All other bits of the written word have no effect.
- R2: Each cycle with `dot_en` high advances the dot position by one. At dots-per-line minus one the dot position returns to 0 and the line advances. At line count minus one the line returns to 0. With `dot_en` low, neither counter moves.
- R3: Bit 4 of a write with `wr_sel` = 1 sets interlace mode. At each line wrap the field flag inverts when interlace is set and holds when it is clear.
- R4: `sync_status` bits 9:0 carry the current line and bit 10 carries the field flag.
- R5: A write with `wr_sel` = 2 sets the horizontal sync width to (bits 6:0 + 1) × 2 dots and the vertical sync line count to bits 11:8. A write with `wr_sel` = 3 sets the front porch to bits 9:0 + 1 dots.
- R6: On a line whose bit 0 equals the field flag, bit 12 is set when the dot position exceeds the horizontal sync width. If the line is not below the vertical sync count, bit 13 is set, and bit 11 is also set when the dot position exceeds the front porch.
- R7: On a line whose bit 0 differs from the field flag and that is not below the vertical sync count, bits 12 and 13 are set. Bit 11 is set while the dot position plus `BACK_PORCH` is below the dots per line. On such a line below the vertical sync count, only bit 12 of bits 13:11 is set.
- R8: `frame_tick` is high for exactly the one cycle in which `line_pos` first shows line `TICK_LINE` (default 42), after arriving from the line before it. `frame_count` increments by one in that same cycle.
- R9: After reset the dot, line, field and frame counters are 0. The configuration is 625 lines of 864 dots, interlace off, sync code 63 (128-dot horizontal sync), 5 vertical sync lines and a front porch code of 0.
- R10: A total-register write zeroes the dot and line counters in the next cycle, even if `dot_en` is high in the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable, one dot per high cycle |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Register select: 0 total, 1 mode, 2 sync timing, 3 front porch |
| wr_data | input | 32 | Write data |
| dot_pos | output | 10 | Dot position within the line |
| line_pos | output | 10 | Current line |
| field_odd | output | 1 | Odd/even field flag |
| frame_tick | output | 1 | One-cycle pulse at the retrace line |
| frame_count | output | FRAME_W | Frames counted since reset |
| sync_status | output | 14 | Sync-status word |

## Verification
The assertions check on every cycle that the counters stay inside the programmed totals, hold when the enable is low and clear after a total write. They also check that the field flag holds with interlace off, that the tick lands only on the retrace line with a single frame increment, and that the vertical-sync flags obey the parity-dependent decode. Only the bench scenarios show the exact dot where each phase flag switches, the field alternation across many interlaced wraps, the absence of ticks when the field is shorter than the retrace line, and the masking of unused write bits. The bench shows these by comparing a behavioural model cycle by cycle under irregular enable patterns.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int CNT_W = 10;

  typedef enum logic [1:0] {
    SEL_TOTAL  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_SYNC   = 2'd2,
    SEL_FPORCH = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] lines_m1;
    logic [CNT_W-1:0] dots_m1;
    logic             interlace;
    logic [6:0]       hs_code;
    logic [3:0]       vs_lines;
    logic [CNT_W-1:0] fp_code;
  } raster_cfg_t;

  localparam raster_cfg_t CFG_RESET = '{
    lines_m1:  10'd624,
    dots_m1:   10'd863,
    interlace: 1'b0,
    hs_code:   7'h3F,
    vs_lines:  4'd5,
    fp_code:   10'd0
  };

endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output raster_cfg_t cfg,
  output logic        total_wr
);

  raster_cfg_t cfg_q, cfg_n;

  assign total_wr = wr_en && (wr_sel == SEL_TOTAL);
  assign cfg      = cfg_q;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_TOTAL: begin
          cfg_n.lines_m1 = wr_data[25:16];
          cfg_n.dots_m1  = wr_data[9:0];
        end
        SEL_MODE: begin
          cfg_n.interlace = wr_data[4];
        end
        SEL_SYNC: begin
          cfg_n.hs_code  = wr_data[6:0];
          cfg_n.vs_lines = wr_data[11:8];
        end
        default: begin
          cfg_n.fp_code = wr_data[9:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_n;
  end

  // R1: total write keeps only its two count fields
  p_total_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    total_wr |=> (cfg_q.lines_m1 == $past(wr_data[25:16])) &&
                 (cfg_q.dots_m1  == $past(wr_data[9:0])));

  // R5: sync write leaves the total fields alone
  p_sync_keeps_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SYNC) |=> $stable(cfg_q.lines_m1) && $stable(cfg_q.dots_m1));

endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int CNT_W     = 10,
  parameter int FRAME_W   = 16,
  parameter int TICK_LINE = 42
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               clr,
  input  logic [CNT_W-1:0]   lines_m1,
  input  logic [CNT_W-1:0]   dots_m1,
  input  logic               interlace,
  output logic [CNT_W-1:0]   dot_q,
  output logic [CNT_W-1:0]   line_q,
  output logic               field_q,
  output logic               tick_q,
  output logic [FRAME_W-1:0] frame_q
);

  localparam logic [CNT_W-1:0] TICK_L = CNT_W'(TICK_LINE);

  logic [CNT_W-1:0]   dot_n, line_n, line_inc;
  logic               field_n, tick_n;
  logic [FRAME_W-1:0] frame_n;
  logic               dot_last, line_last;

  assign dot_last  = (dot_q == dots_m1);
  assign line_last = (line_q == lines_m1);
  assign line_inc  = line_q + 1'b1;

  always_comb begin
    dot_n   = dot_q;
    line_n  = line_q;
    field_n = field_q;
    frame_n = frame_q;
    tick_n  = 1'b0;
    if (clr) begin
      dot_n  = '0;
      line_n = '0;
    end else if (dot_en) begin
      if (dot_last) begin
        dot_n = '0;
        if (line_last) begin
          line_n = '0;
          if (interlace) field_n = ~field_q;
        end else begin
          line_n = line_inc;
          if (line_inc == TICK_L) begin
            tick_n  = 1'b1;
            frame_n = frame_q + 1'b1;
          end
        end
      end else begin
        dot_n = dot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
      tick_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      dot_q   <= dot_n;
      line_q  <= line_n;
      field_q <= field_n;
      tick_q  <= tick_n;
      frame_q <= frame_n;
    end
  end

  p_dot_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dot_q <= dots_m1);

  p_line_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= lines_m1);

  p_hold_without_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dot_en && !clr) |=> $stable(dot_q) && $stable(line_q));

  p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace |=> $stable(field_q));

  p_tick_on_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (line_q == TICK_L));

  p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (frame_q == $past(frame_q) + 1'b1));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dot_q == '0) && (line_q == '0));

endmodule

// File: rtl/raster_status_dec.sv
module raster_status_dec #(
  parameter int CNT_W      = 10,
  parameter int BACK_PORCH = 54
) (
  input  logic [CNT_W-1:0] dot,
  input  logic [CNT_W-1:0] line,
  input  logic             field,
  input  logic [CNT_W-1:0] dots_m1,
  input  logic [6:0]       hs_code,
  input  logic [3:0]       vs_lines,
  input  logic [CNT_W-1:0] fp_code,
  output logic [13:0]      status
);

  localparam int XW = CNT_W + 2;
  localparam logic [XW-1:0] BP_X = XW'(BACK_PORCH);

  logic [XW-1:0] dot_x, hs_w, fp_w, dots_x;
  logic          same_parity, past_vs;
  logic          act, hs_off, vs_off;

  assign dot_x  = XW'(dot);
  assign hs_w   = XW'({hs_code, 1'b0}) + XW'(2);
  assign fp_w   = XW'(fp_code) + XW'(1);
  assign dots_x = XW'(dots_m1) + XW'(1);

  assign same_parity = (line[0] == field);
  assign past_vs     = (line >= CNT_W'(vs_lines));

  always_comb begin
    act    = 1'b0;
    hs_off = 1'b0;
    vs_off = 1'b0;
    if (same_parity) begin
      hs_off = (dot_x > hs_w);
      if (past_vs) begin
        vs_off = 1'b1;
        act    = (dot_x > fp_w);
      end
    end else begin
      hs_off = 1'b1;
      if (past_vs) begin
        vs_off = 1'b1;
        act    = ((dot_x + BP_X) < dots_x);
      end
    end
  end

  assign status = {vs_off, hs_off, act, field, line};

endmodule

// File: rtl/scan_raster.sv
module scan_raster
  import raster_pkg::*;
#(
  parameter int FRAME_W    = 16,
  parameter int BACK_PORCH = 54,
  parameter int TICK_LINE  = 42
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [9:0]         dot_pos,
  output logic [9:0]         line_pos,
  output logic               field_odd,
  output logic               frame_tick,
  output logic [FRAME_W-1:0] frame_count,
  output logic [13:0]        sync_status
);

  raster_cfg_t cfg;
  logic        total_wr;

  raster_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .total_wr (total_wr)
  );

  raster_counters #(
    .CNT_W     (CNT_W),
    .FRAME_W   (FRAME_W),
    .TICK_LINE (TICK_LINE)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .dot_en    (dot_en),
    .clr       (total_wr),
    .lines_m1  (cfg.lines_m1),
    .dots_m1   (cfg.dots_m1),
    .interlace (cfg.interlace),
    .dot_q     (dot_pos),
    .line_q    (line_pos),
    .field_q   (field_odd),
    .tick_q    (frame_tick),
    .frame_q   (frame_count)
  );

  raster_status_dec #(
    .CNT_W      (CNT_W),
    .BACK_PORCH (BACK_PORCH)
  ) u_stat (
    .dot      (dot_pos),
    .line     (line_pos),
    .field    (field_odd),
    .dots_m1  (cfg.dots_m1),
    .hs_code  (cfg.hs_code),
    .vs_lines (cfg.vs_lines),
    .fp_code  (cfg.fp_code),
    .status   (sync_status)
  );

  p_status_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_status[10] == field_odd);

  p_vsync_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos >= 10'(cfg.vs_lines)) |-> sync_status[13]);

  p_other_parity_vsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_pos[0] != field_odd) && (line_pos < 10'(cfg.vs_lines)))
      |-> (sync_status[13:11] == 3'b010));

endmodule

// File: tb/sim_scan_raster.sv
module sim_scan_raster;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dot_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [9:0]  dot_pos, line_pos;
  logic        field_odd, frame_tick;
  logic [15:0] frame_count;
  logic [13:0] sync_status;

  always #5 clk = ~clk;

  scan_raster u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .dot_en      (dot_en),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .dot_pos     (dot_pos),
    .line_pos    (line_pos),
    .field_odd   (field_odd),
    .frame_tick  (frame_tick),
    .frame_count (frame_count),
    .sync_status (sync_status)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_dot, m_line, m_field, m_frame, m_tick;
  int m_lf, m_df, m_il, m_hs, m_vs, m_fp;
  localparam int BP = 54;
  localparam int TICK = 42;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_status();
    int st;
    st = m_line | (m_field << 10);
    if ((m_line & 1) == m_field) begin
      if (m_dot > (m_hs + 1) * 2) st |= (1 << 12);
      if (m_line >= m_vs) begin
        st |= (1 << 13);
        if (m_dot > m_fp + 1) st |= (1 << 11);
      end
    end else begin
      if (m_line >= m_vs) begin
        st |= (3 << 12);
        if (m_dot + BP < m_df + 1) st |= (1 << 11);
      end else begin
        st |= (1 << 12);
      end
    end
    return st;
  endfunction

  task automatic compare_all();
    int exp;
    exp = ref_status();
    chk("R1 R2 dot position", int'(dot_pos), m_dot);
    chk("R1 R2 line position", int'(line_pos), m_line);
    chk("R3 field flag", int'(field_odd), m_field);
    chk("R8 frame tick", int'(frame_tick), m_tick);
    chk("R8 frame count", int'(frame_count), m_frame);
    chk("R4 status line and field", int'(sync_status[10:0]), exp & 32'h7FF);
    if ((m_line & 1) == m_field)
      chk("R5 R6 status phase, matching parity", int'(sync_status[13:11]), (exp >> 11) & 7);
    else
      chk("R7 status phase, other parity", int'(sync_status[13:11]), (exp >> 11) & 7);
  endtask

  task automatic model_reset();
    m_dot = 0; m_line = 0; m_field = 0; m_frame = 0; m_tick = 0;
    m_lf = 624; m_df = 863; m_il = 0; m_hs = 63; m_vs = 5; m_fp = 0;
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit we, input bit [1:0] sel, input bit [31:0] d, input bit den);
    wr_en = we; wr_sel = sel; wr_data = d; dot_en = den;
    @(posedge clk);
    m_tick = 0;
    if (we && sel == 2'd0) begin
      m_lf = int'(d[25:16]); m_df = int'(d[9:0]);
      m_dot = 0; m_line = 0;
    end else if (den) begin
      if (m_dot == m_df) begin
        m_dot = 0;
        if (m_line == m_lf) begin
          m_line = 0;
          if (m_il != 0) m_field = 1 - m_field;
        end else begin
          m_line = m_line + 1;
          if (m_line == TICK) begin
            m_tick = 1;
            m_frame = (m_frame + 1) & 16'hFFFF;
          end
        end
      end else begin
        m_dot = m_dot + 1;
      end
    end
    if (we && sel == 2'd1) m_il = int'(d[4]);
    if (we && sel == 2'd2) begin m_hs = int'(d[6:0]); m_vs = int'(d[11:8]); end
    if (we && sel == 2'd3) m_fp = int'(d[9:0]);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n, input int pattern);
    for (int i = 0; i < n; i++) begin
      bit den;
      case (pattern)
        0: den = 1'b1;
        1: den = (i % 3) != 0;
        2: den = ((i % 7) < 5);
        default: den = 1'b0;
      endcase
      step(1'b0, 2'd0, 32'h0, den);
    end
  endtask

  initial begin
    rst_n = 1'b0; dot_en = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'h0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset dot", int'(dot_pos), 0);
    chk("R9 reset line", int'(line_pos), 0);
    chk("R9 reset field", int'(field_odd), 0);
    chk("R9 reset frame count", int'(frame_count), 0);
    chk("R9 reset tick", int'(frame_tick), 0);
    chk("R9 reset status", int'(sync_status), ref_status());

    // R9: default 864-dot lines and sync code observed while running
    run(2000, 0);
    chk("R9 default line length", int'(line_pos), 2);

    // R1 R10: total write with junk bits and a simultaneous enable
    step(1'b1, 2'd0, 32'hFC31FC63, 1'b1);
    chk("R10 total write clears dot", int'(dot_pos), 0);
    chk("R10 total write clears line", int'(line_pos), 0);

    // R5: sync timing and front porch with ignored bits set
    step(1'b1, 2'd2, 32'hFFFF_F385 & 32'h0000_03FF | 32'h0000_0080, 1'b1);
    step(1'b1, 2'd3, 32'hFFFF_FC14, 1'b0);

    run(16000, 1);     // progressive, two-plus frames
    step(1'b1, 2'd1, 32'hFFFF_FFEF | 32'h10, 1'b1);  // R3 interlace on
    run(24000, 2);     // interlaced fields
    // R8: field shorter than the retrace line, no ticks
    step(1'b1, 2'd0, (32'd29 << 16) | 32'd59, 1'b1);
    run(6000, 0);
    step(1'b1, 2'd1, 32'h0000_0000, 1'b0);  // R3 interlace off
    run(3000, 1);
    step(1'b1, 2'd0, (32'd49 << 16) | 32'd99, 1'b0);
    run(3000, 0);
    // R2: enable low holds position
    run(50, 3);
    run(500, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule